// File: doc/BRIEF.md
# Masked Instruction-Word Breakpoint Matcher

This block watches the stream of decoded 32-bit instruction words and raises a breakpoint pulse when a word matches a programmed pattern. Software does not write a raw bitmask. It writes a pattern word and one enable bit for each instruction-format field. The block turns the field enables into a compare mask. It then stores the pattern already ANDed with that mask, which keeps the per-instruction compare down to one AND and one equality test.

There are two copies of the breakpoint setup. Each copy is shared by a group of four hardware threads, and the group-select bit of the thread identifier picks the copy. This holds for configuration writes, for readback and for instruction checks. A write made from any thread of a group therefore changes the breakpoint seen by all four threads of that group. Trap delivery and the decode pipeline sit outside this block, and the registered hit pulse is handed to them.

Top module: `ibp_matcher`

## Requirements
- R1: After synchronous reset, both copies hold a zero pattern and zero enables, `bp_hit` and `cfg_rvalid` are low, and no instruction matches until a copy has been programmed.
- R2: Enable bit 0 puts instruction bits 4:0 into the mask, bit 1 bits 12:5, bit 2 bit 13, bit 3 bits 18:14, bit 4 bits 24:19, bit 5 bits 29:25 and bit 6 bits 31:30.
- R3: A valid instruction matches when (instruction AND mask) equals (pattern AND mask). Instruction and pattern bits outside the mask have no effect.
- R4: Enable bit 7 is a global enable. While it is clear the copy never matches. While it is set and bits 6:0 are clear, every valid instruction of that group matches.
- R5: `bp_hit` rises in the cycle after a matching instruction is presented with `ins_valid` high, lasts one cycle per instruction, and comes with `bp_tid` equal to that instruction's thread. An instruction with `ins_valid` low never produces a hit.
- R6: Thread-identifier bit 2 selects copy 0 (threads 0-3) or copy 1 (threads 4-7) for writes, reads and instruction checks. A write changes the matching of all four threads in its group and none in the other group.
- R7: A read returns, one cycle later with `cfg_rvalid` pulsed, the pattern word and all eight enable bits exactly as written (the pattern is not masked), plus the requesting thread on `cfg_rtid`. The read outputs hold between reads.
- R8: A write takes effect for instructions presented from the cycle after the write. An instruction presented in the same cycle as the write is compared against the old setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_tid | input | 3 | Thread issuing the access; bit 2 selects the copy |
| cfg_wword | input | 32 | Pattern word to write |
| cfg_wen | input | 8 | Field enables 6:0 and global enable 7 to write |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_rd` |
| cfg_rword | output | 32 | Pattern word read back |
| cfg_ren | output | 8 | Enable bits read back |
| cfg_rtid | output | 3 | Thread that issued the read |
| ins_valid | input | 1 | Instruction word valid |
| ins_tid | input | 3 | Thread of the instruction |
| ins_word | input | 32 | Decoded instruction word |
| bp_hit | output | 1 | Registered breakpoint pulse |
| bp_tid | output | 3 | Thread of the instruction that hit |

## Verification
The assertions assume that reset is held for at least one clock before any traffic. They also assume that `cfg_rd` and `ins_valid` are defined (not X) whenever reset is low. The bench drives every input from known values at falling edges. It releases reset only after several cycles and changes strobes only away from the rising edge. Writes and reads are single-cycle pulses, and instructions are presented either in isolation or together with a write when the R8 ordering is checked. So the stimulus stays within the single-access-per-cycle use that the properties take for granted.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

  localparam int IW_W    = 32;
  localparam int NUM_FLD = 7;
  localparam int EN_W    = NUM_FLD + 1;
  localparam int GLB_BIT = NUM_FLD;

  // Field enable indices (bit positions in the enable byte)
  localparam int FLD_SRC2   = 0;
  localparam int FLD_ALTSPC = 1;
  localparam int FLD_IMMF   = 2;
  localparam int FLD_SRC1   = 3;
  localparam int FLD_OPX    = 4;
  localparam int FLD_DST    = 5;
  localparam int FLD_OPC    = 6;

  // Field owning each instruction bit
  function automatic int fld_of_bit(input int b);
    if (b < 5)       return FLD_SRC2;
    else if (b < 13) return FLD_ALTSPC;
    else if (b < 14) return FLD_IMMF;
    else if (b < 19) return FLD_SRC1;
    else if (b < 25) return FLD_OPX;
    else if (b < 30) return FLD_DST;
    else             return FLD_OPC;
  endfunction

  typedef struct packed {
    logic [IW_W-1:0] mask;
    logic [IW_W-1:0] data;
    logic            glb;
  } bp_cmp_t;

endpackage

// File: rtl/ibp_mask_gen.sv
module ibp_mask_gen
  import ibp_pkg::*;
(
  input  logic [NUM_FLD-1:0] fld_en,
  output logic [IW_W-1:0]    mask
);

  for (genvar b = 0; b < IW_W; b++) begin : g_bit
    localparam int F = fld_of_bit(b);
    assign mask[b] = fld_en[F];
  end

endmodule

// File: rtl/ibp_regbank.sv
module ibp_regbank
  import ibp_pkg::*;
#(
  parameter int TID_W   = 3,
  parameter int GRP_LSB = 2,
  localparam int SEL_W  = TID_W - GRP_LSB,
  localparam int NGRP   = 1 << SEL_W
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [TID_W-1:0]     tid,
  input  logic [IW_W-1:0]      wword,
  input  logic [EN_W-1:0]      wen,
  output logic                 rvalid,
  output logic [IW_W-1:0]      rword,
  output logic [EN_W-1:0]      ren,
  output logic [TID_W-1:0]     rtid,
  output bp_cmp_t [NGRP-1:0]   cmp
);

  logic [SEL_W-1:0] sel;
  logic [IW_W-1:0]  wmask;

  logic [IW_W-1:0]  word_q [NGRP];
  logic [EN_W-1:0]  en_q   [NGRP];

  assign sel = tid[TID_W-1:GRP_LSB];

  ibp_mask_gen u_mask (
    .fld_en (wen[NUM_FLD-1:0]),
    .mask   (wmask)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit_wr;
    assign hit_wr = wr && (sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[g]    <= '0;
        en_q[g]      <= '0;
        cmp[g].mask  <= '0;
        cmp[g].data  <= '0;
        cmp[g].glb   <= 1'b0;
      end else if (hit_wr) begin
        word_q[g]    <= wword;
        en_q[g]      <= wen;
        cmp[g].mask  <= wmask;
        cmp[g].data  <= wword & wmask;
        cmp[g].glb   <= wen[GLB_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rword  <= '0;
      ren    <= '0;
      rtid   <= '0;
    end else begin
      rvalid <= rd;
      if (rd) begin
        rword <= word_q[sel];
        ren   <= en_q[sel];
        rtid  <= tid;
      end
    end
  end

endmodule

// File: rtl/ibp_match.sv
module ibp_match
  import ibp_pkg::*;
#(
  parameter int TID_W   = 3,
  parameter int GRP_LSB = 2,
  localparam int SEL_W  = TID_W - GRP_LSB,
  localparam int NGRP   = 1 << SEL_W
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               ins_valid,
  input  logic [TID_W-1:0]   ins_tid,
  input  logic [IW_W-1:0]    ins_word,
  input  bp_cmp_t [NGRP-1:0] cmp,
  output logic               bp_hit,
  output logic [TID_W-1:0]   bp_tid
);

  logic [NGRP-1:0]  grp_eq;
  logic [SEL_W-1:0] sel;
  logic             hit_d;

  for (genvar g = 0; g < NGRP; g++) begin : g_cmp
    assign grp_eq[g] = cmp[g].glb && ((ins_word & cmp[g].mask) == cmp[g].data);
  end

  assign sel   = ins_tid[TID_W-1:GRP_LSB];
  assign hit_d = ins_valid && grp_eq[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_hit <= 1'b0;
      bp_tid <= '0;
    end else begin
      bp_hit <= hit_d;
      bp_tid <= ins_tid;
    end
  end

endmodule

// File: rtl/ibp_matcher.sv
module ibp_matcher
  import ibp_pkg::*;
#(
  parameter int TID_W   = 3,
  parameter int GRP_LSB = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [TID_W-1:0] cfg_tid,
  input  logic [IW_W-1:0]  cfg_wword,
  input  logic [EN_W-1:0]  cfg_wen,
  output logic             cfg_rvalid,
  output logic [IW_W-1:0]  cfg_rword,
  output logic [EN_W-1:0]  cfg_ren,
  output logic [TID_W-1:0] cfg_rtid,
  input  logic             ins_valid,
  input  logic [TID_W-1:0] ins_tid,
  input  logic [IW_W-1:0]  ins_word,
  output logic             bp_hit,
  output logic [TID_W-1:0] bp_tid
);

  localparam int NGRP = 1 << (TID_W - GRP_LSB);

  bp_cmp_t [NGRP-1:0] cmp;

  ibp_regbank #(.TID_W(TID_W), .GRP_LSB(GRP_LSB)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr     (cfg_wr),
    .rd     (cfg_rd),
    .tid    (cfg_tid),
    .wword  (cfg_wword),
    .wen    (cfg_wen),
    .rvalid (cfg_rvalid),
    .rword  (cfg_rword),
    .ren    (cfg_ren),
    .rtid   (cfg_rtid),
    .cmp    (cmp)
  );

  ibp_match #(.TID_W(TID_W), .GRP_LSB(GRP_LSB)) u_match (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_tid   (ins_tid),
    .ins_word  (ins_word),
    .cmp       (cmp),
    .bp_hit    (bp_hit),
    .bp_tid    (bp_tid)
  );

endmodule

// File: rtl/ibp_matcher_chk.sv
module ibp_matcher_chk #(
  parameter int TID_W = 3
)(
  input logic             clk,
  input logic             rst,
  input logic             cfg_rd,
  input logic             cfg_rvalid,
  input logic [31:0]      cfg_rword,
  input logic             ins_valid,
  input logic [TID_W-1:0] ins_tid,
  input logic             bp_hit,
  input logic [TID_W-1:0] bp_tid
);

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> $past(ins_valid)); // R5

  AST_HIT_TID: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> (bp_tid == $past(ins_tid))); // R5

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> cfg_rvalid); // R7

  AST_RVALID_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> !cfg_rvalid); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> $stable(cfg_rword)); // R7

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!bp_hit && !cfg_rvalid)); // R1

endmodule

bind ibp_matcher ibp_matcher_chk #(.TID_W(TID_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_rd     (cfg_rd),
  .cfg_rvalid (cfg_rvalid),
  .cfg_rword  (cfg_rword),
  .ins_valid  (ins_valid),
  .ins_tid    (ins_tid),
  .bp_hit     (bp_hit),
  .bp_tid     (bp_tid)
);

// File: tb/ibp_matcher_tb.sv
module ibp_matcher_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [2:0]  cfg_tid = '0;
  logic [31:0] cfg_wword = '0;
  logic [7:0]  cfg_wen = '0;
  logic        cfg_rvalid;
  logic [31:0] cfg_rword;
  logic [7:0]  cfg_ren;
  logic [2:0]  cfg_rtid;
  logic        ins_valid = 1'b0;
  logic [2:0]  ins_tid = '0;
  logic [31:0] ins_word = '0;
  logic        bp_hit;
  logic [2:0]  bp_tid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibp_matcher u_dut (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_tid(cfg_tid),
    .cfg_wword(cfg_wword), .cfg_wen(cfg_wen),
    .cfg_rvalid(cfg_rvalid), .cfg_rword(cfg_rword),
    .cfg_ren(cfg_ren), .cfg_rtid(cfg_rtid),
    .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_word(ins_word),
    .bp_hit(bp_hit), .bp_tid(bp_tid)
  );

  // {valid, expected hit, tid, word}
  localparam int NVEC = 11;
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 3'd0, 32'h81A0_0000},
    {1'b1, 1'b1, 3'd3, 32'h81A7_FFFF},
    {1'b1, 1'b0, 3'd1, 32'hC1A0_0000},
    {1'b1, 1'b0, 3'd2, 32'h81A8_0000},
    {1'b1, 1'b1, 3'd4, 32'h0000_2005},
    {1'b1, 1'b1, 3'd7, 32'hFFFF_E005},
    {1'b1, 1'b0, 3'd5, 32'h0000_0005},
    {1'b1, 1'b0, 3'd6, 32'h0000_2006},
    {1'b1, 1'b0, 3'd0, 32'h0000_2005},
    {1'b1, 1'b0, 3'd4, 32'h81A0_0000},
    {1'b0, 1'b0, 3'd0, 32'h81A0_0000}
  };

  function automatic int f_lo(input int k);
    case (k)
      0: return 0;  1: return 5;  2: return 13; 3: return 14;
      4: return 19; 5: return 25; default: return 30;
    endcase
  endfunction

  function automatic int f_hi(input int k);
    case (k)
      0: return 4;  1: return 12; 2: return 13; 3: return 18;
      4: return 24; 5: return 29; default: return 31;
    endcase
  endfunction

  function automatic logic [31:0] f_mask(input int k);
    logic [31:0] m = '0;
    for (int b = f_lo(k); b <= f_hi(k); b++) m[b] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] t, input logic [31:0] w, input logic [7:0] e);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_tid = t; cfg_wword = w; cfg_wen = e;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input string req, input logic [2:0] t,
                          input logic [31:0] ew, input logic [7:0] ee);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_tid = t;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(req, {31'd0, cfg_rvalid}, 32'd1);
    chk(req, cfg_rword, ew);
    chk(req, {24'd0, cfg_ren}, {24'd0, ee});
    chk(req, {29'd0, cfg_rtid}, {29'd0, t});
  endtask

  task automatic present(input string req, input logic v, input logic [2:0] t,
                         input logic [31:0] w, input logic exp);
    @(negedge clk);
    ins_valid = v; ins_tid = t; ins_word = w;
    @(negedge clk);
    ins_valid = 1'b0;
    chk(req, {31'd0, bp_hit}, {31'd0, exp});
    if (exp) chk(req, {29'd0, bp_tid}, {29'd0, t});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1", {31'd0, bp_hit}, 32'd0);
    chk("R1", {31'd0, cfg_rvalid}, 32'd0);
    cfg_read("R1", 3'd0, 32'd0, 8'd0);
    cfg_read("R1", 3'd4, 32'd0, 8'd0);
    present("R1", 1'b1, 3'd0, 32'd0, 1'b0);

    // R8: write and instruction in the same cycle use the old setup
    @(negedge clk);
    cfg_wr = 1'b1; cfg_tid = 3'd1; cfg_wword = 32'h0; cfg_wen = 8'h80;
    ins_valid = 1'b1; ins_tid = 3'd0; ins_word = 32'h1234_5678;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R8", {31'd0, bp_hit}, 32'd0);
    @(negedge clk);
    ins_valid = 1'b0;
    chk("R8", {31'd0, bp_hit}, 32'd1);

    // R4: global enable alone matches everything in its group only
    present("R4", 1'b1, 3'd2, 32'hDEAD_BEEF, 1'b1);
    present("R6", 1'b1, 3'd4, 32'hDEAD_BEEF, 1'b0);
    cfg_write(3'd3, 32'h0, 8'h00);
    present("R4", 1'b1, 3'd0, 32'h0, 1'b0);
    cfg_write(3'd0, 32'h0, 8'h7F);
    present("R4", 1'b1, 3'd1, 32'h0, 1'b0);

    // R2: each field enable covers exactly its bits
    for (int k = 0; k < 7; k++) begin
      cfg_write(3'd2, 32'h0, 8'h80 | 8'(1 << k));
      present("R2", 1'b1, 3'd0, ~f_mask(k), 1'b1);
      present("R2", 1'b1, 3'd1, 32'd1 << f_lo(k), 1'b0);
      present("R2", 1'b1, 3'd3, 32'd1 << f_hi(k), 1'b0);
    end

    // R3/R6: vector table
    cfg_write(3'd1, 32'h81A0_0FFF, 8'hD0);
    cfg_write(3'd6, 32'h0000_2005, 8'h85);
    for (int i = 0; i < NVEC; i++) begin
      present("R3", VEC[i][36], VEC[i][34:32], VEC[i][31:0], VEC[i][35]);
    end

    // R7: readback unmodified
    cfg_read("R7", 3'd2, 32'h81A0_0FFF, 8'hD0);
    cfg_read("R7", 3'd5, 32'h0000_2005, 8'h85);
    @(negedge clk);
    chk("R7", {31'd0, cfg_rvalid}, 32'd0);
    chk("R7", cfg_rword, 32'h0000_2005);

    // R5: one-cycle pulse
    present("R5", 1'b1, 3'd3, 32'h81A0_0000, 1'b1);
    @(negedge clk);
    chk("R5", {31'd0, bp_hit}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule